// File: doc/BRIEF.md
# Multi-Mode Three-Phase PI Current Controller

This block is the fast control loop engine of a three-phase power converter board. Once per switching period a start pulse makes it run up to three current-regulating PI loops and up to three outer voltage PI loops. It produces three modulation values for the PWM stage and pulses `done` when they are ready. All arithmetic is signed Q1.15, and it runs on one shared multiplier that steps through the phases in sequence.

In inverter mode each phase has two nested loops. An outer voltage PI loop turns the voltage error into a current reference, clamped to the device current capability. An inner current PI loop, with feed-forward from the voltage reference and from the measured voltage, produces the phase command. In rectifier mode the voltage loops are bypassed. The current references come from outside, only phases 0 and 1 run a current loop, and phase 2 is the negated sum of the other two. In both modes every current-loop output is multiplied by the supplied reciprocal of the DC-link voltage, so the loop gain does not depend on the link voltage. Gains and limits are taken from input ports. They, and every measured and reference input, must be held steady from the start pulse until `done`.

Top module: `phase_pi_bank`

## Requirements
- R1: After reset, `mod_out` is all zero, `done` is low and all six integrators are zero.
- R2: A start pulse seen while idle begins one update. `done` is a one-cycle pulse, issued 21 cycles after the start edge in inverter mode and 7 cycles after it in rectifier mode. `mod_out` changes only together with `done`. A start pulse seen while an update is running is ignored.
- R3: All values are signed Q1.15. A product is floor(a*b / 2^15). Every product, sum and difference is saturated to [-32768, 32767].
- R4: Inverter voltage loop for each phase: the error ev is sat(v_ref - v_meas). The current reference is clamp(sat(kp_v*ev + vint), ±lim_cur).
- R5: Current loop for each phase: the error ei is sat(iref - i_meas). The command is u = clamp(sat(sat(kp_i*ei + iint) + ff), ±lim_mod). In inverter mode ff = sat(kff_ref*v_ref + kff_meas*v_meas). In rectifier mode ff = 0.
- R6: Each phase output is u*vdc_inv in Q1.15. Every current-loop output has magnitude no greater than lim_mod. Phase p occupies `mod_out` bits [16p+15:16p].
- R7: Each integrator updates to clamp(sat(int + ki*e), ±limit), using this run's error. vint uses lim_int_v and iint uses lim_int_i. The new value takes effect in the next run.
- R8: An integrator keeps its value in any run where its own stage output was clamped by lim_cur (voltage stage) or lim_mod (current stage).
- R9: In rectifier mode, phases 0 and 1 take their current reference from `i_ref_ext`. Phase 2 output is sat(-(m0 + m1)). `v_ref` and `v_meas` have no effect on the outputs.
- R10: When the mode sampled at a start differs from the mode of the previous run, all integrators are cleared before that run. The mode is `rect_mode` = 0 for inverter and 1 for rectifier, and the previous mode after reset is inverter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins one update when idle |
| rect_mode | input | 1 | 0 inverter, 1 rectifier; sampled at start |
| v_ref | input | 48 | Voltage references, phase p at [16p+15:16p] |
| v_meas | input | 48 | Measured phase voltages |
| i_meas | input | 48 | Measured phase currents |
| i_ref_ext | input | 48 | Current references used in rectifier mode |
| vdc_inv | input | 16 | Reciprocal of DC-link voltage, Q1.15 |
| kp_v | input | 16 | Voltage loop proportional gain |
| ki_v | input | 16 | Voltage loop integral gain |
| kp_i | input | 16 | Current loop proportional gain |
| ki_i | input | 16 | Current loop integral gain |
| kff_ref | input | 16 | Feed-forward gain on voltage reference |
| kff_meas | input | 16 | Feed-forward gain on measured voltage |
| lim_cur | input | 16 | Voltage-stage output clamp (current capability) |
| lim_int_v | input | 16 | Voltage integrator clamp |
| lim_int_i | input | 16 | Current integrator clamp |
| lim_mod | input | 16 | Current-stage output clamp |
| done | output | 1 | One-cycle pulse marking new outputs |
| mod_out | output | 48 | Three modulation values |

## Verification
On every cycle the assertions check the following port-level behaviour:
- `done` is a single-cycle pulse.
- `mod_out` holds between pulses.
- The latency from start to `done` is exact in each mode.
- Each current-loop output stays within lim_mod.
- In rectifier mode, phase 2 equals the saturated negative sum of the other two phases.

The saturation and Q1.15 rounding arithmetic, the feed-forward terms, the DC-link rescaling, integrator accumulation and clamping, anti-windup holds, integrator clearing on a mode change and the ignoring of voltage inputs in rectifier mode depend on values built up over several runs. Only the bench's scenarios, compared against its own model, can show them.

// File: rtl/phase_pi_bank.sv
module phase_pi_bank #(
  parameter int DW = 16
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rect_mode,
  input  logic [3*DW-1:0]   v_ref,
  input  logic [3*DW-1:0]   v_meas,
  input  logic [3*DW-1:0]   i_meas,
  input  logic [3*DW-1:0]   i_ref_ext,
  input  logic [DW-1:0]     vdc_inv,
  input  logic [DW-1:0]     kp_v,
  input  logic [DW-1:0]     ki_v,
  input  logic [DW-1:0]     kp_i,
  input  logic [DW-1:0]     ki_i,
  input  logic [DW-1:0]     kff_ref,
  input  logic [DW-1:0]     kff_meas,
  input  logic [DW-1:0]     lim_cur,
  input  logic [DW-1:0]     lim_int_v,
  input  logic [DW-1:0]     lim_int_i,
  input  logic [DW-1:0]     lim_mod,
  output logic              done,
  output logic [3*DW-1:0]   mod_out
);
  localparam int NPH = 3;
  localparam int FRAC = DW - 1;

  typedef logic signed [DW-1:0] s_t;
  typedef logic signed [DW+1:0] w_t;
  typedef enum logic [3:0] {S_IDLE, S_VP, S_VI, S_F1, S_F2, S_IP, S_II, S_SC, S_DER} st_t;

  localparam w_t MAXV = w_t'((1 <<< FRAC) - 1);
  localparam w_t MINV = -MAXV - w_t'(1);

  function automatic w_t ext(input s_t a);
    return w_t'(a);
  endfunction

  function automatic s_t sat(input w_t x);
    if (x > MAXV) return s_t'(MAXV);
    if (x < MINV) return s_t'(MINV);
    return s_t'(x);
  endfunction

  function automatic s_t add(input s_t a, input s_t b);
    return sat(ext(a) + ext(b));
  endfunction

  function automatic s_t sub(input s_t a, input s_t b);
    return sat(ext(a) - ext(b));
  endfunction

  function automatic s_t clamp(input s_t x, input s_t l);
    s_t nl;
    nl = -l;
    if (x > l) return l;
    if (x < nl) return nl;
    return x;
  endfunction

  function automatic s_t mul(input s_t a, input s_t b);
    logic signed [2*DW-1:0] pr;
    pr = a * b;
    pr = pr >>> FRAC;
    return sat($signed(pr[DW+1:0]));
  endfunction

  st_t        st;
  logic [1:0] ph;
  logic       rect_q, vclip, iclip;
  s_t         vint [NPH];
  s_t         iint [NPH];
  s_t         stage [2];
  s_t         iref_r, ff_r, cur_r;

  s_t vr, vm, im, ir, ev, ei, iref_e, ff_e, ma, mb, p;
  s_t v_raw, v_lim, i_raw, i_lim, vint_nx, iint_nx;

  assign vr = s_t'(v_ref[ph*DW +: DW]);
  assign vm = s_t'(v_meas[ph*DW +: DW]);
  assign im = s_t'(i_meas[ph*DW +: DW]);
  assign ir = s_t'(i_ref_ext[ph*DW +: DW]);

  assign ev     = sub(vr, vm);
  assign iref_e = rect_q ? ir : iref_r;
  assign ff_e   = rect_q ? s_t'(0) : ff_r;
  assign ei     = sub(iref_e, im);

  always_comb begin
    ma = s_t'(kp_v);
    mb = ev;
    case (st)
      S_VI: begin ma = s_t'(ki_v);     mb = ev; end
      S_F1: begin ma = s_t'(kff_ref);  mb = vr; end
      S_F2: begin ma = s_t'(kff_meas); mb = vm; end
      S_IP: begin ma = s_t'(kp_i);     mb = ei; end
      S_II: begin ma = s_t'(ki_i);     mb = ei; end
      S_SC: begin ma = cur_r;          mb = s_t'(vdc_inv); end
      default: ;
    endcase
  end

  assign p       = mul(ma, mb);
  assign v_raw   = add(p, vint[ph]);
  assign v_lim   = clamp(v_raw, s_t'(lim_cur));
  assign i_raw   = add(add(p, iint[ph]), ff_e);
  assign i_lim   = clamp(i_raw, s_t'(lim_mod));
  assign vint_nx = clamp(add(vint[ph], p), s_t'(lim_int_v));
  assign iint_nx = clamp(add(iint[ph], p), s_t'(lim_int_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      ph      <= '0;
      rect_q  <= 1'b0;
      vclip   <= 1'b0;
      iclip   <= 1'b0;
      iref_r  <= '0;
      ff_r    <= '0;
      cur_r   <= '0;
      done    <= 1'b0;
      mod_out <= '0;
      for (int k = 0; k < NPH; k++) begin
        vint[k] <= '0;
        iint[k] <= '0;
      end
      for (int k = 0; k < 2; k++) stage[k] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          rect_q <= rect_mode;
          ph     <= '0;
          if (rect_mode != rect_q)
            for (int k = 0; k < NPH; k++) begin
              vint[k] <= '0;
              iint[k] <= '0;
            end
          st <= rect_mode ? S_IP : S_VP;
        end
        S_VP: begin
          iref_r <= v_lim;
          vclip  <= (v_raw != v_lim);
          st     <= S_VI;
        end
        S_VI: begin
          if (!vclip) vint[ph] <= vint_nx;
          st <= S_F1;
        end
        S_F1: begin
          ff_r <= p;
          st   <= S_F2;
        end
        S_F2: begin
          ff_r <= add(ff_r, p);
          st   <= S_IP;
        end
        S_IP: begin
          cur_r <= i_lim;
          iclip <= (i_raw != i_lim);
          st    <= S_II;
        end
        S_II: begin
          if (!iclip) iint[ph] <= iint_nx;
          st <= S_SC;
        end
        S_SC: begin
          if (ph < 2'd2) stage[ph[0]] <= p;
          if (rect_q && ph == 2'd1) begin
            st <= S_DER;
          end else if (ph == 2'd2) begin
            mod_out <= {p, stage[1], stage[0]};
            done    <= 1'b1;
            st      <= S_IDLE;
          end else begin
            ph <= ph + 2'd1;
            st <= rect_q ? S_IP : S_VP;
          end
        end
        S_DER: begin
          mod_out <= {sat(-(ext(stage[0]) + ext(stage[1]))), stage[1], stage[0]};
          done    <= 1'b1;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/phase_pi_bank_chk.sv
module phase_pi_bank_chk #(
  parameter int DW = 16
)(
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            rect_mode,
  input logic [DW-1:0]   lim_mod,
  input logic            done,
  input logic [3*DW-1:0] mod_out
);
  logic busy_c, rect_c;
  int   cnt_c;
  int   m0, m1, m2, lm, der;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_c <= 1'b0;
      rect_c <= 1'b0;
      cnt_c  <= 0;
    end else if (start && (!busy_c || done)) begin
      busy_c <= 1'b1;
      rect_c <= rect_mode;
      cnt_c  <= 0;
    end else if (done) begin
      busy_c <= 1'b0;
    end else if (busy_c) begin
      cnt_c <= cnt_c + 1;
    end
  end

  always_comb begin
    m0  = int'($signed(mod_out[DW-1:0]));
    m1  = int'($signed(mod_out[2*DW-1:DW]));
    m2  = int'($signed(mod_out[3*DW-1:2*DW]));
    lm  = int'($signed(lim_mod));
    der = -(m0 + m1);
    if (der > (1 <<< (DW-1)) - 1) der = (1 <<< (DW-1)) - 1;
    if (der < -(1 <<< (DW-1))) der = -(1 <<< (DW-1));
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(mod_out)); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (busy_c && cnt_c == (rect_c ? 7 : 21))); // R2
  AST_MOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (m0 <= lm && m0 >= -lm && m1 <= lm && m1 >= -lm && (rect_c || (m2 <= lm && m2 >= -lm)))); // R6
  AST_RECT_DERIVE: assert property (@(posedge clk) disable iff (!rst_n) (done && rect_c) |-> m2 == der); // R9
endmodule

bind phase_pi_bank phase_pi_bank_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rect_mode(rect_mode),
  .lim_mod(lim_mod), .done(done), .mod_out(mod_out)
);

// File: tb/phase_pi_bank_bench.sv
`timescale 1ns/1ps
module phase_pi_bank_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic rect_mode = 1'b0;
  logic [47:0] v_ref = '0, v_meas = '0, i_meas = '0, i_ref_ext = '0;
  logic [15:0] vdc_inv = '0, kp_v = '0, ki_v = '0, kp_i = '0, ki_i = '0;
  logic [15:0] kff_ref = '0, kff_meas = '0, lim_cur = '0, lim_int_v = '0, lim_int_i = '0, lim_mod = '0;
  logic        done;
  logic [47:0] mod_out;

  always #2 clk = ~clk;

  phase_pi_bank u_phase_pi_bank (
    .clk(clk), .rst_n(rst_n), .start(start), .rect_mode(rect_mode),
    .v_ref(v_ref), .v_meas(v_meas), .i_meas(i_meas), .i_ref_ext(i_ref_ext),
    .vdc_inv(vdc_inv), .kp_v(kp_v), .ki_v(ki_v), .kp_i(kp_i), .ki_i(ki_i),
    .kff_ref(kff_ref), .kff_meas(kff_meas), .lim_cur(lim_cur),
    .lim_int_v(lim_int_v), .lim_int_i(lim_int_i), .lim_mod(lim_mod),
    .done(done), .mod_out(mod_out)
  );

  typedef struct { int m [3]; string tag; } exp_t;
  exp_t sb [$];

  int n_run = 0, n_fail = 0;
  int vr [3], vm [3], im [3], ir [3];
  int kpv, kiv, kpi, kii, kfr, kfm, lc, liv, lii, lm, vinv;
  int vi_m [3], ii_m [3];
  bit mode_m = 1'b0;

  function automatic int msat(int x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction
  function automatic int mmul(int a, int b);
    int pr;
    pr = a * b;
    return msat(pr >>> 15);
  endfunction
  function automatic int mclamp(int x, int l);
    if (x > l) return l;
    if (x < -l) return -l;
    return x;
  endfunction

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        check("R2 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        for (int p = 0; p < 3; p++)
          check(e.tag, int'($signed(mod_out[16*p +: 16])), e.m[p]);
      end
    end
  end

  task automatic model(bit rect, string tag);
    exp_t e;
    int ev, raw, iref, ff, ei, u;
    if (rect != mode_m) begin
      for (int k = 0; k < 3; k++) begin vi_m[k] = 0; ii_m[k] = 0; end
      mode_m = rect;
    end
    for (int p = 0; p < (rect ? 2 : 3); p++) begin
      if (rect) begin
        iref = ir[p];
        ff = 0;
      end else begin
        ev = msat(vr[p] - vm[p]);
        raw = msat(mmul(kpv, ev) + vi_m[p]);
        iref = mclamp(raw, lc);
        if (raw == iref) vi_m[p] = mclamp(msat(vi_m[p] + mmul(kiv, ev)), liv);
        ff = msat(mmul(kfr, vr[p]) + mmul(kfm, vm[p]));
      end
      ei = msat(iref - im[p]);
      raw = msat(msat(mmul(kpi, ei) + ii_m[p]) + ff);
      u = mclamp(raw, lm);
      if (raw == u) ii_m[p] = mclamp(msat(ii_m[p] + mmul(kii, ei)), lii);
      e.m[p] = mmul(u, vinv);
    end
    if (rect) e.m[2] = msat(-(e.m[0] + e.m[1]));
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic run(bit rect, string tag, bit extra);
    int cyc, late;
    model(rect, tag);
    @(negedge clk);
    rect_mode = rect;
    for (int p = 0; p < 3; p++) begin
      v_ref[16*p +: 16] = 16'(vr[p]);
      v_meas[16*p +: 16] = 16'(vm[p]);
      i_meas[16*p +: 16] = 16'(im[p]);
      i_ref_ext[16*p +: 16] = 16'(ir[p]);
    end
    kp_v = 16'(kpv); ki_v = 16'(kiv); kp_i = 16'(kpi); ki_i = 16'(kii);
    kff_ref = 16'(kfr); kff_meas = 16'(kfm); lim_cur = 16'(lc);
    lim_int_v = 16'(liv); lim_int_i = 16'(lii); lim_mod = 16'(lm); vdc_inv = 16'(vinv);
    start = 1'b1;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) start = 1'b0;
      if (extra && cyc == 4) start = 1'b1;
      if (extra && cyc == 5) start = 1'b0;
      if (done || cyc > 100) break;
    end
    check("R2 latency", cyc, rect ? 8 : 22);
    if (extra) begin
      late = 0;
      repeat (30) begin
        @(negedge clk);
        if (done) late++;
      end
      check("R2 start while busy ignored", late, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    kpv = 16384; kiv = 3277; kpi = 24576; kii = 1638; kfr = 8192; kfm = -4096;
    lc = 20000; liv = 10000; lii = 8000; lm = 30000; vinv = 32767;
    vr = '{1000, -2000, 3000}; vm = '{900, -1500, 2500};
    im = '{100, -300, 200}; ir = '{0, 0, 0};
    repeat (3) @(negedge clk);
    check("R1 mod_out after reset", int'(mod_out != 0), 0);
    check("R1 done after reset", int'(done), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(1'b0, "R4", 1'b0);
    run(1'b0, "R5", 1'b0);
    vr = '{-4000, 6000, 12000}; vm = '{-3000, 7000, 10000};
    run(1'b0, "R7", 1'b0);
    vinv = 16384;
    run(1'b0, "R6", 1'b0);
    vinv = 32767;
    vr = '{-32768, 32767, 0}; vm = '{32767, -32768, 0};
    run(1'b0, "R3", 1'b0);
    lc = 2000; lm = 5000; kii = 16384;
    vr = '{20000, -20000, 500}; vm = '{0, 0, 0}; im = '{0, 0, 0};
    repeat (3) run(1'b0, "R8", 1'b0);
    lc = 20000; lm = 30000; kiv = 16384;
    vr = '{1500, -1200, 800}; vm = '{1000, -1000, 600}; im = '{200, -100, 50};
    repeat (6) run(1'b0, "R7", 1'b0);

    ir = '{3000, -5000, 9999}; im = '{1000, -1000, 0};
    run(1'b1, "R10", 1'b0);
    run(1'b1, "R9", 1'b0);
    vr = '{30000, -30000, 12345}; vm = '{-7000, 7000, -1};
    run(1'b1, "R9", 1'b0);
    ir = '{30000, 30000, 0}; im = '{-30000, -30000, 0};
    run(1'b1, "R9", 1'b1);
    vr = '{1000, -2000, 3000}; vm = '{900, -1500, 2500}; im = '{100, -300, 200};
    run(1'b0, "R10", 1'b0);
    run(1'b0, "R5", 1'b1);

    repeat (5) @(negedge clk);
    check("R2 scoreboard drained", sb.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule